// File: doc/BRIEF.md
# Reorder Buffer with Exception Flush

This block is the in-order instruction window of an out-of-order core. Dispatch takes a free slot at the tail and receives that slot's number as the rename tag. Execution units later deliver a result against that tag, together with an exception flag. Entries leave only from the head, in program order, and only once their result is present. Each departing entry drives its destination register, value and tag toward the register file and rename table.

Tags run from 1 to DEPTH, with slot index i carrying tag i+1. Tag 0 is reserved to mean "value already architectural", so completions carrying it are dropped. An entry that finished with an exception does not retire. When it reaches the head it raises a one-cycle flush pulse. In that same clock edge every slot and both pointers return to their reset state, and dispatch resumes at tag 1.

DEPTH must be a power of two. Each pointer carries one extra wrap bit that separates a full buffer from an empty one.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty: disp_ready_o is 1, disp_tag_o is 1, ret_valid_o is 0 and flush_o is 0.
- R2: Consecutive accepted dispatches receive tags 1, 2, …, DEPTH, then 1 again (slot index plus one), and disp_tag_o changes only on an accepted dispatch or a flush.
- R3: With DEPTH entries outstanding, disp_ready_o is 0 and a dispatch request is ignored: the tag offered afterwards is unchanged, and it is the next tag in sequence once a slot frees.
- R4: A completion to an allocated entry stores the value and marks the entry done; if that entry is the head, ret_valid_o is 1 in the following cycle.
- R5: While the head entry is not done, nothing retires, even when younger entries are done.
- R6: At most one entry retires per cycle, always the head, with ret_dest_o, ret_value_o and ret_tag_o equal to that entry's destination, stored value and tag.
- R7: A completion with tag 0, with a tag above DEPTH, or with a tag naming a slot that is not allocated, changes nothing: a slot allocated later still waits for its own completion.
- R8: A done head entry whose exception flag is set raises flush_o for exactly one cycle, with ret_valid_o and disp_ready_o both 0. In the next cycle the buffer is empty, disp_tag_o is 1, and completions to the discarded tags are ignored.
- R9: An allocation and a retirement can occur in the same cycle, leaving the occupancy unchanged.
- R10: An exception on an entry that is not the head causes no flush until all older entries have retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| disp_valid_i | input | 1 | Dispatch request |
| disp_dest_i | input | REG_W | Destination register of the dispatched instruction |
| disp_ready_o | output | 1 | A slot is free and no flush is in progress |
| disp_tag_o | output | TAG_W | Tag the next accepted dispatch receives |
| cmpl_valid_i | input | 1 | Result broadcast valid |
| cmpl_tag_i | input | TAG_W | Tag of the producing entry |
| cmpl_value_i | input | DATA_W | Result value |
| cmpl_exc_i | input | 1 | Result carries an exception |
| ret_valid_o | output | 1 | Head entry retires this cycle |
| ret_dest_o | output | REG_W | Destination register of the retiring entry |
| ret_value_o | output | DATA_W | Value of the retiring entry |
| ret_tag_o | output | TAG_W | Tag of the retiring entry |
| flush_o | output | 1 | Faulting head: clear the machine |

## Verification
The checker keeps its own occupancy count and checks it against disp_ready_o on every cycle. It also checks the step of the dispatch tag, the strict tag order of retirements, and the single-cycle flush pulse that lands on an empty buffer.

Other properties depend on specific sequences and are left to the bench scenarios. These are: the values and destinations retired, the head blocking younger finished work, stray completions being dropped, and a non-head exception waiting until the older entries have gone.

// File: rtl/reorder_buf_pkg.sv
package reorder_buf_pkg;
  typedef enum logic [1:0] {
    HD_EMPTY,
    HD_BUSY,
    HD_RETIRE,
    HD_FAULT
  } head_state_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             clear_i,
  output logic [IDX_W-1:0] head_idx_o,
  output logic [IDX_W-1:0] tail_idx_o,
  output logic             full_o
);
  logic [IDX_W:0] head_q, tail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (clear_i) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (push_i) tail_q <= tail_q + 1'b1;
      if (pop_i)  head_q <= head_q + 1'b1;
    end
  end

  assign head_idx_o = head_q[IDX_W-1:0];
  assign tail_idx_o = tail_q[IDX_W-1:0];
  // same slot, opposite lap
  assign full_o = (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]) && (head_q[IDX_W] != tail_q[IDX_W]);
endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array #(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              alloc_en_i,
  input  logic [IDX_W-1:0]  alloc_idx_i,
  input  logic [REG_W-1:0]  alloc_dest_i,
  input  logic              cmpl_en_i,
  input  logic [IDX_W-1:0]  cmpl_idx_i,
  input  logic [DATA_W-1:0] cmpl_data_i,
  input  logic              cmpl_exc_i,
  input  logic              free_en_i,
  input  logic [IDX_W-1:0]  free_idx_i,
  output logic [DEPTH-1:0]  valid_o,
  output logic [DEPTH-1:0]  done_o,
  output logic [DEPTH-1:0]  exc_o,
  output logic [REG_W-1:0]  dest_o [DEPTH],
  output logic [DATA_W-1:0] data_o [DEPTH]
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic hit_alloc, hit_cmpl, hit_free;
    assign hit_alloc = alloc_en_i && (alloc_idx_i == IDX_W'(e));
    assign hit_cmpl  = cmpl_en_i  && (cmpl_idx_i  == IDX_W'(e));
    assign hit_free  = free_en_i  && (free_idx_i  == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[e] <= 1'b0;
        done_o[e]  <= 1'b0;
        exc_o[e]   <= 1'b0;
        dest_o[e]  <= '0;
        data_o[e]  <= '0;
      end else if (clear_i) begin
        valid_o[e] <= 1'b0;
        done_o[e]  <= 1'b0;
        exc_o[e]   <= 1'b0;
      end else if (hit_alloc) begin
        valid_o[e] <= 1'b1;
        done_o[e]  <= 1'b0;
        exc_o[e]   <= 1'b0;
        dest_o[e]  <= alloc_dest_i;
      end else if (hit_free) begin
        valid_o[e] <= 1'b0;
        done_o[e]  <= 1'b0;
      end else if (hit_cmpl) begin
        done_o[e]  <= 1'b1;
        exc_o[e]   <= cmpl_exc_i;
        data_o[e]  <= cmpl_data_i;
      end
    end
  end
endmodule

// File: rtl/rob_head_eval.sv
module rob_head_eval
  import reorder_buf_pkg::*;
(
  input  logic        valid_i,
  input  logic        done_i,
  input  logic        exc_i,
  output head_state_e state_o
);
  always_comb begin
    if (!valid_i)     state_o = HD_EMPTY;
    else if (!done_i) state_o = HD_BUSY;
    else if (exc_i)   state_o = HD_FAULT;
    else              state_o = HD_RETIRE;
  end
endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
  import reorder_buf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int TAG_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_valid_i,
  input  logic [REG_W-1:0]  disp_dest_i,
  output logic              disp_ready_o,
  output logic [TAG_W-1:0]  disp_tag_o,
  input  logic              cmpl_valid_i,
  input  logic [TAG_W-1:0]  cmpl_tag_i,
  input  logic [DATA_W-1:0] cmpl_value_i,
  input  logic              cmpl_exc_i,
  output logic              ret_valid_o,
  output logic [REG_W-1:0]  ret_dest_o,
  output logic [DATA_W-1:0] ret_value_o,
  output logic [TAG_W-1:0]  ret_tag_o,
  output logic              flush_o
);
  logic [IDX_W-1:0]  head_idx, tail_idx, cmpl_idx;
  logic [TAG_W-1:0]  cmpl_off;
  logic              full, disp_fire, ret_fire, flush, cmpl_en;
  logic [DEPTH-1:0]  ent_valid, ent_done, ent_exc;
  logic [REG_W-1:0]  ent_dest [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];
  head_state_e       head_st;

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (disp_fire),
    .pop_i      (ret_fire),
    .clear_i    (flush),
    .head_idx_o (head_idx),
    .tail_idx_o (tail_idx),
    .full_o     (full)
  );

  // tag 0 -> offset wraps to all ones, top bit rejects it with tags above DEPTH
  assign cmpl_off = cmpl_tag_i - TAG_W'(1);
  assign cmpl_idx = cmpl_off[IDX_W-1:0];
  assign cmpl_en  = cmpl_valid_i && !cmpl_off[IDX_W] && ent_valid[cmpl_idx] && !flush;

  rob_entry_array #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_arr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (flush),
    .alloc_en_i   (disp_fire),
    .alloc_idx_i  (tail_idx),
    .alloc_dest_i (disp_dest_i),
    .cmpl_en_i    (cmpl_en),
    .cmpl_idx_i   (cmpl_idx),
    .cmpl_data_i  (cmpl_value_i),
    .cmpl_exc_i   (cmpl_exc_i),
    .free_en_i    (ret_fire),
    .free_idx_i   (head_idx),
    .valid_o      (ent_valid),
    .done_o       (ent_done),
    .exc_o        (ent_exc),
    .dest_o       (ent_dest),
    .data_o       (ent_data)
  );

  rob_head_eval u_head (
    .valid_i (ent_valid[head_idx]),
    .done_i  (ent_done[head_idx]),
    .exc_i   (ent_exc[head_idx]),
    .state_o (head_st)
  );

  assign flush        = (head_st == HD_FAULT);
  assign ret_fire     = (head_st == HD_RETIRE);
  assign disp_ready_o = !full && !flush;
  assign disp_fire    = disp_valid_i && disp_ready_o;
  assign disp_tag_o   = {1'b0, tail_idx} + TAG_W'(1);

  assign ret_valid_o = ret_fire;
  assign ret_dest_o  = ent_dest[head_idx];
  assign ret_value_o = ent_data[head_idx];
  assign ret_tag_o   = {1'b0, head_idx} + TAG_W'(1);
  assign flush_o     = flush;
endmodule

// File: rtl/reorder_buf_chk.sv
module reorder_buf_chk #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             disp_valid_i,
  input logic             disp_ready_o,
  input logic [TAG_W-1:0] disp_tag_o,
  input logic             ret_valid_o,
  input logic [TAG_W-1:0] ret_tag_o,
  input logic             flush_o
);
  logic [TAG_W:0]   occ;
  logic [TAG_W-1:0] last_tag;
  logic             have_last;
  logic             fire;

  assign fire = disp_valid_i && disp_ready_o;

  function automatic logic [TAG_W-1:0] step_tag(input logic [TAG_W-1:0] t);
    return (t == TAG_W'(DEPTH)) ? TAG_W'(1) : t + TAG_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ       <= '0;
      last_tag  <= '0;
      have_last <= 1'b0;
    end else if (flush_o) begin
      occ       <= '0;
      have_last <= 1'b0;
    end else begin
      occ <= occ + (TAG_W+1)'(fire) - (TAG_W+1)'(ret_valid_o);
      if (ret_valid_o) begin
        last_tag  <= ret_tag_o;
        have_last <= 1'b1;
      end
    end
  end

  // R3
  ready_tracks_occ_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_o |-> (disp_ready_o == (occ < (TAG_W+1)'(DEPTH))));
  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= (TAG_W+1)'(DEPTH));
  // R2
  tag_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> disp_tag_o == step_tag($past(disp_tag_o)));
  // R2
  tag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fire && !flush_o) |=> $stable(disp_tag_o));
  // R6
  retire_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_o && have_last) |-> ret_tag_o == step_tag(last_tag));
  // R8
  flush_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (!ret_valid_o && !disp_ready_o));
  // R8
  flush_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (!flush_o && !ret_valid_o && disp_ready_o && disp_tag_o == TAG_W'(1)));
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ == '0) |-> (!ret_valid_o && !flush_o));
endmodule

bind reorder_buf reorder_buf_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .disp_valid_i (disp_valid_i),
  .disp_ready_o (disp_ready_o),
  .disp_tag_o   (disp_tag_o),
  .ret_valid_o  (ret_valid_o),
  .ret_tag_o    (ret_tag_o),
  .flush_o      (flush_o)
);

// File: tb/tb_reorder_buf.sv
`timescale 1ns/1ps
module tb_reorder_buf;
  localparam int DEPTH  = 8;
  localparam int REG_W  = 5;
  localparam int DATA_W = 32;
  localparam int TAG_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              disp_valid = 1'b0;
  logic [REG_W-1:0]  disp_dest = '0;
  logic              disp_ready;
  logic [TAG_W-1:0]  disp_tag;
  logic              cmpl_valid = 1'b0;
  logic [TAG_W-1:0]  cmpl_tag = '0;
  logic [DATA_W-1:0] cmpl_value = '0;
  logic              cmpl_exc = 1'b0;
  logic              ret_valid;
  logic [REG_W-1:0]  ret_dest;
  logic [DATA_W-1:0] ret_value;
  logic [TAG_W-1:0]  ret_tag;
  logic              flush;

  typedef struct packed {
    logic [REG_W-1:0]  dest;
    logic [DATA_W-1:0] val;
    logic [TAG_W-1:0]  tag;
  } exp_t;

  exp_t              sb_q[$];
  exp_t              sb_e;
  logic [DATA_W-1:0] plan [DEPTH+1];
  int total = 0, bad = 0, retired = 0, flushes = 0;
  logic [TAG_W-1:0]  t;

  always #2.5 clk = ~clk;

  reorder_buf #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .disp_valid_i(disp_valid), .disp_dest_i(disp_dest),
    .disp_ready_o(disp_ready), .disp_tag_o(disp_tag),
    .cmpl_valid_i(cmpl_valid), .cmpl_tag_i(cmpl_tag),
    .cmpl_value_i(cmpl_value), .cmpl_exc_i(cmpl_exc),
    .ret_valid_o(ret_valid), .ret_dest_o(ret_dest),
    .ret_value_o(ret_value), .ret_tag_o(ret_tag), .flush_o(flush)
  );

  task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // scoreboard monitor: one look per cycle, after the edge
  initial forever begin
    @(posedge clk);
    #1;
    if (rst_n) begin
      if (flush) flushes++;
      if (ret_valid) begin
        if (sb_q.size() == 0) begin
          check_eq("R6 retire with nothing expected", 64'(ret_tag), 0);
        end else begin
          sb_e = sb_q.pop_front();
          check_eq("R6 retire dest", 64'(ret_dest), 64'(sb_e.dest));
          check_eq("R6 retire value", 64'(ret_value), 64'(sb_e.val));
          check_eq("R6 retire tag", 64'(ret_tag), 64'(sb_e.tag));
          retired++;
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  task automatic step();
    @(negedge clk);
    disp_valid = 1'b0;
    cmpl_valid = 1'b0;
    cmpl_exc   = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic dispatch(input logic [REG_W-1:0] dest, input logic [DATA_W-1:0] val,
                          output logic [TAG_W-1:0] tag);
    tag = disp_tag;
    if (disp_ready) begin
      sb_q.push_back('{dest: dest, val: val, tag: tag});
      plan[tag] = val;
    end
    disp_valid = 1'b1;
    disp_dest  = dest;
    step();
  endtask

  task automatic complete(input logic [TAG_W-1:0] tag, input logic [DATA_W-1:0] val, input logic exc);
    cmpl_valid = 1'b1;
    cmpl_tag   = tag;
    cmpl_value = val;
    cmpl_exc   = exc;
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check_eq("R1 ready", 64'(disp_ready), 1);
    check_eq("R1 tag", 64'(disp_tag), 1);
    check_eq("R1 ret_valid", 64'(ret_valid), 0);
    check_eq("R1 flush", 64'(flush), 0);

    // R2 first tags
    dispatch(5'd3, 32'h100, t); check_eq("R2 tag a", 64'(t), 1);
    dispatch(5'd4, 32'h200, t); check_eq("R2 tag b", 64'(t), 2);
    dispatch(5'd5, 32'h300, t); check_eq("R2 tag c", 64'(t), 3);

    // R5 younger done, head pending
    complete(4'd2, 32'h200, 1'b0);
    idle(2);
    check_eq("R5 head pending ret_valid", 64'(ret_valid), 0);
    check_eq("R5 nothing retired", 64'(retired), 0);

    // R4 head completion visible next cycle
    complete(4'd1, 32'h100, 1'b0);
    check_eq("R4 head retires next cycle", 64'(ret_valid), 1);
    check_eq("R4 head tag", 64'(ret_tag), 1);
    complete(4'd3, 32'h300, 1'b0);
    idle(2);
    check_eq("R4 three retired", 64'(retired), 3);

    // R7 stray completions: tag 0, out of range, unallocated slot
    complete(4'd0, 32'hdead, 1'b0);
    complete(4'd12, 32'hdead, 1'b0);
    complete(4'd5, 32'hbeef, 1'b0);
    dispatch(5'd6, 32'h400, t); check_eq("R2 tag d", 64'(t), 4);
    dispatch(5'd7, 32'h500, t); check_eq("R2 tag e", 64'(t), 5);
    idle(3);
    check_eq("R7 stray ignored ret_valid", 64'(ret_valid), 0);
    check_eq("R7 stray ignored retired", 64'(retired), 3);
    complete(4'd5, 32'h500, 1'b0);
    complete(4'd4, 32'h400, 1'b0);
    idle(3);
    check_eq("R4 five retired", 64'(retired), 5);

    // R3 fill, wrapping tags
    for (int i = 0; i < DEPTH; i++) begin
      dispatch(5'(10 + i), 32'h1000 + 32'(i), t);
      check_eq("R2 wrap tag", 64'(t), 64'(((5 + i) % DEPTH) + 1));
    end
    check_eq("R3 full ready low", 64'(disp_ready), 0);
    dispatch(5'd31, 32'hbad, t);
    check_eq("R3 full tag held", 64'(disp_tag), 6);
    check_eq("R3 still full", 64'(disp_ready), 0);
    complete(4'd6, plan[6], 1'b0);
    idle(1);
    check_eq("R3 ready after free", 64'(disp_ready), 1);
    check_eq("R3 next tag in sequence", 64'(disp_tag), 6);

    // R9 allocate while retiring
    complete(4'd7, plan[7], 1'b0);
    check_eq("R9 retire pending", 64'(ret_valid), 1);
    dispatch(5'd20, 32'h2000, t);
    check_eq("R9 tag given", 64'(t), 6);
    check_eq("R9 occupancy kept", 64'(disp_ready), 1);
    check_eq("R9 next tag", 64'(disp_tag), 7);
    complete(4'd8, plan[8], 1'b0);
    for (int k = 1; k <= 6; k++) complete(4'(k), plan[k], 1'b0);
    idle(4);
    check_eq("R6 all retired", 64'(retired), 14);
    check_eq("R6 scoreboard drained", 64'(sb_q.size()), 0);

    // R10 non-head exception waits
    dispatch(5'd1, 32'h3000, t); check_eq("R2 tag f", 64'(t), 7);
    dispatch(5'd2, 32'h3001, t);
    dispatch(5'd3, 32'h3002, t);
    complete(4'd8, 32'h3001, 1'b1);
    complete(4'd1, 32'h3002, 1'b0);
    idle(2);
    check_eq("R10 no early flush", 64'(flush), 0);
    check_eq("R10 nothing retired", 64'(retired), 14);
    complete(4'd7, 32'h3000, 1'b0);
    check_eq("R10 older retires first", 64'(ret_valid), 1);
    step();
    // R8 flush cycle
    check_eq("R8 flush high", 64'(flush), 1);
    check_eq("R8 no retire in flush", 64'(ret_valid), 0);
    check_eq("R8 dispatch blocked", 64'(disp_ready), 0);
    check_eq("R10 older retired", 64'(retired), 15);
    sb_q.delete();
    step();
    check_eq("R8 flush one cycle", 64'(flush), 0);
    check_eq("R8 restart tag", 64'(disp_tag), 1);
    check_eq("R8 ready after flush", 64'(disp_ready), 1);
    check_eq("R8 empty after flush", 64'(ret_valid), 0);
    check_eq("R8 single pulse", 64'(flushes), 1);

    // R8 late completion to discarded tag is ignored
    complete(4'd1, 32'hdead, 1'b0);
    dispatch(5'd9, 32'h77, t);
    check_eq("R8 first tag after flush", 64'(t), 1);
    idle(2);
    check_eq("R8 stale completion ignored", 64'(ret_valid), 0);
    complete(4'd1, 32'h77, 1'b0);
    idle(2);
    check_eq("R6 final retired", 64'(retired), 16);
    check_eq("R6 final drained", 64'(sb_q.size()), 0);
    summary();
  end
endmodule